// File: doc/BRIEF.md
# PCI Interrupt Line Steering Block

This block collects the four interrupt pins (INTA to INTD) of each PCI device on a bus and presents them to a 16-input legacy interrupt controller. Each pin is first rotated onto one of four shared request lines. The rotation amount comes from the device number held in bits 7:3 of the device's device/function byte. The shared line levels are registered. A small table of four byte-wide routing entries then chooses which legacy IRQ output each shared line drives.

The routing entries are loaded through a byte-wide configuration write port at offsets 0x60 to 0x63, one entry per shared line. An entry holding a value below 16 steers its line onto that IRQ number. Any larger value, including the reset value 0x80, leaves the line unconnected. When several shared lines are steered to the same IRQ, that output is the OR of their levels. The device/function numbers are strap inputs that are expected to stay fixed while the block runs.

Top module: `pci_irq_steer`

## Requirements
- R1: While reset is asserted and after it is released, every IRQ output is low, even when all device pins are high. Reset clears the four latched line levels and sets every routing entry to 0x80 (unrouted).
- R2: The pin of device d at `dev_pins` bit d*4+p, where p = 0..3 stands for INTA..INTD, drives shared line (p + s - 1) mod 4. Here s is bits 7:3 of that device's byte in `dev_devfn` (bits d*8+7:d*8). Slot 0 wraps, so INTA goes to line 3.
- R3: A shared line's level is the OR of every device pin that rotates onto it.
- R4: A write with `cfg_we` high to offset 0x60+n (n = 0..3) stores `cfg_wdata` in the routing entry of shared line n. A stored value v below 16 makes line n drive bit v of `irq_out`.
- R5: A routing entry holding a value from 16 to 255 connects its line to no output.
- R6: When two or more shared lines carry the same routing value below 16, that IRQ output is the OR of their levels.
- R7: A configuration write to any offset outside 0x60 to 0x63 changes no routing entry and has no effect on the outputs.
- R8: A routing change shows at the outputs right after the clock edge that stores it. The IRQ the line left goes low unless another active line still selects it.
- R9: An IRQ output with no active, routed line selecting it is driven low.
- R10: A change on the device pins reaches `irq_out` after exactly one rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_pins | input | 16 | Interrupt pin levels, 4 per device, INTA at the low bit |
| dev_devfn | input | 32 | Device/function number of each device, one byte per device |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration write offset |
| cfg_wdata | input | 8 | Configuration write data |
| irq_out | output | 16 | Level outputs to the legacy interrupt controller |

## Verification
The assertions assume that `dev_devfn` is a strap input that holds one value while the block is out of reset. The bench therefore changes device numbers only while reset is asserted, and the route and pin settings only after it is released. They also assume that every high IRQ output can be traced to an active, latched shared line. The bench sweeps several device-number layouts, including slot 0, slots that share a line, and the largest slot. Each layout is paired with a routing table that mixes distinct targets, shared targets and disabled entries. Several thousand pin patterns are applied, and each result is compared with an arithmetic model of the rotation and OR rules.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned PINS_PER   = 4;
  typedef logic [CFG_W-1:0] cfg_byte_t;
endpackage

// File: rtl/irq_pin_rotate.sv
module irq_pin_rotate #(
  parameter int unsigned NUM_DEV   = 4,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned NPINS    = NUM_DEV * NUM_LINES
) (
  input  logic [NPINS-1:0]          dev_pins,
  input  logic [NUM_DEV*LINE_W-1:0] dev_slot,
  output logic [NUM_LINES-1:0]      line_req
);
  logic [NPINS-1:0][NUM_LINES-1:0] pin_hit;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    for (genvar p = 0; p < NUM_LINES; p++) begin : g_pin
      logic [LINE_W-1:0] tgt;
      // (pin + slot - 1) modulo the line count; power of two wraps for free
      assign tgt = LINE_W'(p) + dev_slot[d*LINE_W +: LINE_W] + LINE_W'(NUM_LINES-1);
      assign pin_hit[d*NUM_LINES+p] =
        {{(NUM_LINES-1){1'b0}}, dev_pins[d*NUM_LINES+p]} << tgt;
    end
  end

  always_comb begin
    line_req = '0;
    for (int i = 0; i < NPINS; i++) line_req = line_req | pin_hit[i];
  end
endmodule

// File: rtl/irq_level_latch.sv
module irq_level_latch #(
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_req,
  output logic [NUM_LINES-1:0] line_q
);
  logic [NUM_LINES-1:0] line_d;
  logic                 line_en;

  always_comb begin
    line_en = 1'b1;
    line_d  = line_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned ROUTE_BASE  = 'h60,
  parameter int unsigned ROUTE_RESET = 'h80
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  cfg_byte_t                       cfg_addr,
  input  cfg_byte_t                       cfg_wdata,
  output logic [NUM_LINES-1:0][CFG_W-1:0] route_q
);
  logic [NUM_LINES-1:0]            hit;
  logic [NUM_LINES-1:0][CFG_W-1:0] route_d;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_hit
    assign hit[l] = cfg_we && (cfg_addr == CFG_W'(ROUTE_BASE + l));

    assert_entry_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[l] |=> (route_q[l] == $past(cfg_wdata)));
  end

  always_comb begin
    route_d = route_q;
    for (int l = 0; l < NUM_LINES; l++)
      if (hit[l]) route_d[l] = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     route_q <= {NUM_LINES{CFG_W'(ROUTE_RESET)}};
    else if (|hit)  route_q <= route_d;
  end

  assert_foreign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(cfg_addr >= CFG_W'(ROUTE_BASE) &&
                 cfg_addr <  CFG_W'(ROUTE_BASE + NUM_LINES))) |=> $stable(route_q));
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_IRQ   = 16
) (
  input  logic [NUM_LINES-1:0]            line_q,
  input  logic [NUM_LINES-1:0][CFG_W-1:0] route_q,
  output logic [NUM_IRQ-1:0]              irq_out
);
  logic [NUM_LINES-1:0] routed;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_ok
    assign routed[l] = ({1'b0, route_q[l]} < (CFG_W+1)'(NUM_IRQ));
  end

  always_comb begin
    irq_out = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      for (int l = 0; l < NUM_LINES; l++)
        if (line_q[l] && routed[l] && (route_q[l] == CFG_W'(k)))
          irq_out[k] = 1'b1;
  end
endmodule

// File: rtl/pci_irq_steer.sv
module pci_irq_steer
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_DEV     = 4,
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned NUM_IRQ     = 16,
  parameter int unsigned ROUTE_BASE  = 'h60,
  parameter int unsigned ROUTE_RESET = 'h80,
  parameter int unsigned SLOT_LSB    = 3,
  localparam int unsigned LINE_W     = $clog2(NUM_LINES),
  localparam int unsigned IRQ_W      = $clog2(NUM_IRQ)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_DEV*NUM_LINES-1:0] dev_pins,
  input  logic [NUM_DEV*CFG_W-1:0]     dev_devfn,
  input  logic                         cfg_we,
  input  logic [CFG_W-1:0]             cfg_addr,
  input  logic [CFG_W-1:0]             cfg_wdata,
  output logic [NUM_IRQ-1:0]           irq_out
);
  logic [1:0]                      rst_sync;
  logic                            rst_q;
  logic [NUM_DEV*LINE_W-1:0]       dev_slot;
  logic [NUM_LINES-1:0]            line_req;
  logic [NUM_LINES-1:0]            line_q;
  logic [NUM_LINES-1:0][CFG_W-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
    assign dev_slot[d*LINE_W +: LINE_W] = dev_devfn[d*CFG_W + SLOT_LSB +: LINE_W];
  end

  irq_pin_rotate #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_rotate (
    .dev_pins (dev_pins),
    .dev_slot (dev_slot),
    .line_req (line_req)
  );

  irq_level_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .clk      (clk),
    .rst_n    (rst_q),
    .line_req (line_req),
    .line_q   (line_q)
  );

  irq_route_table #(
    .NUM_LINES(NUM_LINES), .ROUTE_BASE(ROUTE_BASE), .ROUTE_RESET(ROUTE_RESET)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_q),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .route_q   (route_q)
  );

  irq_fanout #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_fanout (
    .line_q  (line_q),
    .route_q (route_q),
    .irq_out (irq_out)
  );

  // Strap inputs must hold while out of reset (R2 relies on it)
  assert_devfn_static_R2: assert property (@(posedge clk) disable iff (!rst_q)
    $stable(dev_devfn));

  assert_line_count_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(line_q) <= $countones($past(dev_pins)));

  assert_unrouted_quiet_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (route_q[0] >= CFG_W'(NUM_IRQ) && route_q[1] >= CFG_W'(NUM_IRQ) &&
     route_q[NUM_LINES-2] >= CFG_W'(NUM_IRQ) && route_q[NUM_LINES-1] >= CFG_W'(NUM_IRQ) &&
     NUM_LINES == 4) |-> (irq_out == '0));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    assert_shared_or_R6: assert property (@(posedge clk) disable iff (!rst_q)
      (line_q[l] && ({1'b0, route_q[l]} < (CFG_W+1)'(NUM_IRQ)))
        |-> irq_out[route_q[l][IRQ_W-1:0]]);
  end

  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_out != '0) |-> (line_q != '0));

  always @(posedge clk) begin
    if (!rst_q) assert_reset_quiet_R1: assert (irq_out == '0);
  end
endmodule

// File: tb/sim_pci_irq_steer.sv
`timescale 1ns/1ps
module sim_pci_irq_steer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] dev_pins;
  logic [31:0] dev_devfn;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [15:0] irq_out;

  int total = 0;
  int bad   = 0;
  logic [3:0][7:0] shadow;

  always #10 clk = ~clk;

  pci_irq_steer u0 (
    .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .dev_devfn(dev_devfn),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] model(logic [15:0] pins, logic [31:0] dfn,
                                        logic [3:0][7:0] rt);
    logic [3:0]  ln;
    logic [15:0] o;
    int s;
    ln = '0;
    o  = '0;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++)
        if (pins[d*4+p]) begin
          s = int'(dfn[d*8+3 +: 5]);
          ln[((p + s - 1) % 4 + 4) % 4] = 1'b1;
        end
    for (int l = 0; l < 4; l++)
      if (ln[l] && rt[l] < 8'd16) o[rt[l][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    total++;
    if (irq_out !== exp) begin
      bad++;
      $display("FAIL %s: irq_out=%h expected=%h", tag, irq_out, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) shadow[a - 8'h60] = v;
  endtask

  task automatic restart(input logic [31:0] dfn);
    @(negedge clk);
    rst_n = 1'b0; dev_pins = 16'hFFFF; dev_devfn = dfn; cfg_we = 1'b0;
    shadow = {4{8'h80}};
    repeat (2) @(negedge clk);
    check("R1 in reset", 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 R5 after reset, routes 0x80", 16'h0000);
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      dev_pins = 16'(i * 40503);
      @(negedge clk);
      check("R2 R3 R4 R5 R6 R9 sweep", model(dev_pins, dev_devfn, shadow));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dev_pins = 16'hFFFF; dev_devfn = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    shadow = {4{8'h80}};

    // Layout A: slots 1,2,3,4 - single-pin walk, each line to its own IRQ
    restart({8'h20, 8'h18, 8'h10, 8'h08});
    wr(8'h60, 8'd0); wr(8'h61, 8'd1); wr(8'h62, 8'd2); wr(8'h63, 8'd3);
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++) begin
        dev_pins = 16'(1) << (d*4+p);
        @(negedge clk);
        check("R2 single pin", 16'(1) << (((p + d + 1 - 1) % 4)));
      end
    wr(8'h60, 8'd5); wr(8'h61, 8'd9); wr(8'h62, 8'd10); wr(8'h63, 8'd11);
    sweep(4096);

    // R10: pin change waits one rising edge
    dev_pins = 16'h0000;
    @(negedge clk);
    check("R9 idle", 16'h0000);
    dev_pins = 16'h0001;
    #5 check("R10 before edge", 16'h0000);
    @(negedge clk);
    check("R10 after edge", 16'h0020);

    // R8: move line 0 from IRQ5 to IRQ6
    wr(8'h60, 8'd6);
    check("R8 moved", 16'h0040);
    wr(8'h60, 8'h10);
    check("R5 R8 disabled by 0x10", 16'h0000);
    wr(8'h60, 8'd5);
    check("R4 re-enabled", 16'h0020);

    // R7: writes outside the table
    wr(8'h64, 8'd0); check("R7 offset 0x64", 16'h0020);
    wr(8'h5F, 8'd1); check("R7 offset 0x5F", 16'h0020);
    wr(8'hE0, 8'd2); check("R7 offset 0xE0", 16'h0020);
    dev_pins = 16'hFFFF;
    @(negedge clk);
    check("R7 table intact", model(dev_pins, dev_devfn, shadow));

    // Layout B: slot 0 wrap, shared slots; all lines to one IRQ
    restart({8'h09, 8'h08, 8'h28, 8'h00});
    dev_pins = 16'h0001;
    wr(8'h63, 8'd12);
    check("R2 slot 0 wraps to line 3", 16'h1000);
    wr(8'h60, 8'd3); wr(8'h61, 8'd3); wr(8'h62, 8'd3); wr(8'h63, 8'd3);
    sweep(2048);

    // Layout C: all devices at slot 7; disabled and shared entries
    restart({8'h3F, 8'h3A, 8'h39, 8'h38});
    wr(8'h60, 8'h80); wr(8'h61, 8'd15); wr(8'h62, 8'h10); wr(8'h63, 8'd0);
    sweep(2048);

    // Layout D: slot 31 and others; 0xFF entry, two lines sharing IRQ7
    restart({8'h30, 8'h00, 8'h10, 8'hF8});
    wr(8'h60, 8'd7); wr(8'h61, 8'hFF); wr(8'h62, 8'd7); wr(8'h63, 8'd1);
    sweep(2048);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule